// File: doc/BRIEF.md
# Per-Engine Instruction Dispatch Front End

This block sits between an instruction fetch stream and five independent compute engines. Each incoming word is 64 bits wide. The top four bits select the target engine and the low 60 bits are that engine's payload. The block strips the selector and writes the payload into a small queue owned by the target engine. Every engine drains its own queue with a valid/ready handshake at its own pace. A slow engine therefore only holds back the instructions meant for it.

The input stream also uses valid/ready. An instruction is taken only when its target queue has room. If the queue is full, the word waits at the input, unchanged, until that engine frees a slot. Selector values beyond the five engines are treated as illegal. They are taken and dropped at once, and they set an error flag that stays high until reset.

Top module: `vliw_dispatch`

## Requirements
- R1: After reset every out_valid bit is 0, illegal_seen is 0, and in_ready is 1 for any legal selector.
- R2: A word with selector in_word[63:60] equal to 0, 1, 2, 3 or 4 is delivered to engine N, where N is the selector value. Its body in_word[59:0] appears on out_body[N*60 +: 60]. No other engine receives it. The engines are 0 vector-matrix, 1 matrix-matrix, 2 memory copy, 3 constant write and 4 element-wise nonlinear.
- R3: The bodies leaving each engine's port appear in the same order as the input accepted them.
- R4: A word with selector 5 to 15 is accepted at once (in_ready is 1), produces no output on any engine, and sets illegal_seen on the next clock.
- R5: illegal_seen stays 1 until reset and is cleared by reset.
- R6: in_ready is 0 exactly when the presented word is legal and its target queue already holds DEPTH (default 8) entries. A held word is neither lost nor reordered.
- R7: While one engine is stalled with a full queue, the other engines keep delivering their queued bodies.
- R8: While out_valid[N] is 1 and out_ready[N] is 0, out_valid[N] stays 1 and the body on that port is held.
- R9: out_valid[N] is 1 exactly when queue N holds at least one entry. A body accepted into an empty queue is presented on the clock after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 64 | Selector [63:60] and body [59:0] |
| in_ready | output | 1 | Word taken at this edge if in_valid |
| out_valid | output | 5 | Per-engine body available |
| out_ready | input | 5 | Per-engine pop |
| out_body | output | 300 | Engine N body at bits [N*60 +: 60] |
| illegal_seen | output | 1 | Sticky illegal-selector flag |

## Verification
The bench runs a random mix of legal and illegal selectors. Each engine gets its own random back-pressure, and a bench-side queue per engine predicts every output. One phase starves the memory-copy engine until its queue fills. This targets a design that lets in_ready fall for every word instead of only those aimed at the full queue, which would freeze the whole stream. It also targets a design that overwrites the oldest entry when full, which shows up as a lost or out-of-order body. Illegal selectors are mixed in to catch designs that enqueue them into engine 0 or an aliased engine, or that clear the flag. Every cycle the bench checks the exact value of in_ready against queue occupancy and checks that bodies hold while stalled. This catches off-by-one full detection and outputs that change while they wait.

// File: rtl/vliw_dispatch.sv
module vliw_dispatch #(
  parameter int WORD_W  = 64,
  parameter int OP_W    = 4,
  parameter int ENGINES = 5,
  parameter int DEPTH   = 8,
  localparam int BODY_W = WORD_W - OP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [WORD_W-1:0]         in_word,
  output logic                      in_ready,
  output logic [ENGINES-1:0]        out_valid,
  input  logic [ENGINES-1:0]        out_ready,
  output logic [ENGINES*BODY_W-1:0] out_body,
  output logic                      illegal_seen
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [OP_W-1:0]    op;
  logic               legal;
  logic [ENGINES-1:0] sel, full, push;
  logic               fire;

  assign op       = in_word[WORD_W-1 -: OP_W];
  assign legal    = (32'(op) < ENGINES);
  assign sel      = legal ? (ENGINES'(1) << op) : '0;
  assign in_ready = !legal || !(|(sel & full));
  assign fire     = in_valid && in_ready;
  assign push     = fire ? sel : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 illegal_seen <= 1'b0;
    else if (fire && !legal)    illegal_seen <= 1'b1;

  for (genvar e = 0; e < ENGINES; e++) begin : g_q
    logic [BODY_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic              pop;

    assign full[e]      = (cnt == CW'(DEPTH));
    assign out_valid[e] = (cnt != '0);
    assign pop          = out_valid[e] && out_ready[e];
    assign out_body[e*BODY_W +: BODY_W] = mem[rp];

    always_ff @(posedge clk)
      if (push[e]) mem[wp] <= in_word[BODY_W-1:0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push[e]) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop)     rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        case ({push[e], pop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push[e] |-> (cnt < CW'(DEPTH)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[e] && !out_ready[e]) |=>
        (out_valid[e] && $stable(out_body[e*BODY_W +: BODY_W])));
    p_first_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push[e] && cnt == '0) |=>
        (out_valid[e] && out_body[e*BODY_W +: BODY_W] == $past(in_word[BODY_W-1:0])));
  end

  p_onehot_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  p_illegal_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |-> (in_ready && push == '0));
  p_illegal_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |=> illegal_seen);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_seen |=> illegal_seen);
endmodule

// File: tb/vliw_dispatch_bench.sv
module vliw_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int E  = 5;
  localparam int D  = 8;
  localparam int BW = 60;
  localparam int SB = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic in_ready;
  logic [E-1:0] out_valid;
  logic [E-1:0] out_ready = '0;
  logic [E*BW-1:0] out_body;
  logic illegal_seen;

  vliw_dispatch u_vliw_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_body(out_body), .illegal_seen(illegal_seen));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  logic [BW-1:0] exp_mem [E][SB];
  int hd[E], tl[E], occ[E];
  int rdy_pct[E];
  int ill_pct = 0;
  bit exp_ill = 0, taken = 0;
  bit pv[E], pr[E];
  logic [BW-1:0] pb[E];
  int other_pops = 0;

  always @(posedge clk) cycles++;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = '0; taken = 0;
    for (int e = 0; e < E; e++) begin hd[e] = 0; tl[e] = 0; pv[e] = 0; pr[e] = 0; end
    exp_ill = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == '0, "R1", 64'(out_valid), 0);
    chk(illegal_seen == 1'b0, "R1", 64'(illegal_seen), 0);
    chk(in_ready == 1'b1, "R1", 64'(in_ready), 1);
  endtask

  task automatic step(input int watch_eng);
    logic [3:0] op;
    @(negedge clk);
    for (int e = 0; e < E; e++) begin
      logic [BW-1:0] b;
      b = out_body[e*BW +: BW];
      chk(out_valid[e] == (tl[e] != hd[e]), "R9", 64'(out_valid[e]), 64'(tl[e] != hd[e]));
      if (out_valid[e] && tl[e] != hd[e])
        chk(b == exp_mem[e][hd[e] % SB], "R3", 64'(b), 64'(exp_mem[e][hd[e] % SB]));
      if (pv[e] && !pr[e])
        chk(out_valid[e] && b == pb[e], "R8", 64'(b), 64'(pb[e]));
    end
    chk(illegal_seen == exp_ill, "R5", 64'(illegal_seen), 64'(exp_ill));
    for (int e = 0; e < E; e++) occ[e] = tl[e] - hd[e];
    for (int e = 0; e < E; e++) begin
      bit r;
      r = ($urandom_range(0, 99) < rdy_pct[e]);
      out_ready[e] = r;
      pv[e] = out_valid[e]; pr[e] = r; pb[e] = out_body[e*BW +: BW];
      if (r && out_valid[e]) begin
        hd[e]++;
        if (watch_eng >= 0 && e != watch_eng && occ[watch_eng] == D) other_pops++;
      end
    end
    if (!in_valid || taken) begin
      taken = 0;
      in_valid = ($urandom_range(0, 9) != 0);
      op = ($urandom_range(0, 99) < ill_pct) ? 4'($urandom_range(5, 15)) : 4'($urandom_range(0, 4));
      in_word = {op, 28'($urandom), 32'($urandom)};
    end
    #1;
    op = in_word[63:60];
    if (in_valid) begin
      bit er;
      er = (op >= E) || (occ[op] < D);
      chk(in_ready == er, "R6", 64'(in_ready), 64'(er));
      if (in_ready) begin
        taken = 1;
        if (op < E) begin
          exp_mem[op][tl[op] % SB] = in_word[BW-1:0];
          tl[op]++;
        end else exp_ill = 1;
      end
    end
  endtask

  initial begin
    do_reset();
    // R2/R3/R4/R8/R9 random mix with independent back-pressure
    for (int e = 0; e < E; e++) rdy_pct[e] = 30 + 15 * e;
    ill_pct = 0;
    repeat (400) step(-1);
    chk(illegal_seen == 1'b0, "R4", 64'(illegal_seen), 0);
    ill_pct = 10;
    repeat (2000) step(-1);
    // R7: starve engine 2 so its queue fills
    for (int e = 0; e < E; e++) rdy_pct[e] = 80;
    rdy_pct[2] = 0;
    ill_pct = 0;
    repeat (1000) step(2);
    chk(other_pops > 0, "R7", 64'(other_pops), 1);
    rdy_pct[2] = 60;
    repeat (500) step(-1);
    // R2 with all engines fast
    for (int e = 0; e < E; e++) rdy_pct[e] = 100;
    repeat (500) step(-1);
    // R5: reset clears the sticky flag
    chk(illegal_seen == 1'b1, "R5", 64'(illegal_seen), 1);
    do_reset();
    chk(illegal_seen == 1'b0, "R5", 64'(illegal_seen), 0);
    ill_pct = 100;
    repeat (50) step(-1);
    chk(out_valid == '0, "R4", 64'(out_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    vectors++; fails++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule